// File: doc/BRIEF.md
# Lockable Core Configuration Register

This block is the software-visible configuration word of a processor core. A single write port loads a halt request, a one-way write lock, the two cache enables, a data burst-select flag and two 2-bit refill size codes. A combinational read port returns the stored value. Interrupt and non-maskable interrupt lines wake the core out of halt. A bus-busy input holds the cache settings that drive the cache while a refill is in progress.

The cache-facing outputs are an active shadow copy of the software fields. The shadow copy is reloaded on every clock edge where the bus is idle. When it is reloaded, the refill size codes are decoded into registered word counts. Reads always show the newest software value, even while the shadow copy is still holding older settings. The halt state drives the power controller directly. The same state also drives a snoop-inhibit line, because the data cache cannot be snooped while the core is halted.

Top module: `core_cfg_reg`

## Requirements
- R1: After reset, the read value is 0x30: instruction cache enable (bit 5) and data cache enable (bit 4) are 1, and the halt (bit 8), lock (bit 7), burst-select (bit 6), instruction size (bits 3:2) and data size (bits 1:0) fields are all 0. At the same time `icache_en`=1, `dcache_en`=1, `ilen_words`=4, `dlen_words`=1, `halt_mode`=0 and `snoop_inhibit`=0.
- R2: A write while unlocked stores bits 8:0. A read in the following cycle returns them, even while `bus_busy` is high.
- R3: Bits 31:9 are ignored on write and always read as 0.
- R4: A size code of 00, 01, 10 or 11 decodes to 4, 8, 16 or 32 words. The instruction size code drives `ilen_words`.
- R5: When burst-select (bit 6) is 0, `dlen_words` is 1. When it is 1, `dlen_words` is the decode of the data size code.
- R6: Changes to the cache enables, size codes or burst-select reach the outputs one clock after the stored value changes, provided `bus_busy` is low. While `bus_busy` is high, the outputs hold their value. The new settings are applied at the first edge where `bus_busy` is low.
- R7: Writing 1 to bit 8 sets `halt_mode` and `snoop_inhibit` on the next clock. Writing 0 to bit 8 clears them.
- R8: A high `irq` or `nmi` clears halt on the next clock. This does not depend on any interrupt mask, and it wins over a write to bit 8 in the same cycle.
- R9: Once the lock bit (bit 7) is 1, every later write is ignored. This includes writes that try to clear the lock. Only reset clears the lock.
- R10: A write that sets the lock bit still applies all the other fields it carries.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current stored configuration word |
| irq | input | 1 | Interrupt request; wakes from halt |
| nmi | input | 1 | Non-maskable interrupt; wakes from halt |
| bus_busy | input | 1 | High while a refill is in progress; holds the cache outputs |
| icache_en | output | 1 | Active instruction cache enable |
| dcache_en | output | 1 | Active data cache enable |
| ilen_words | output | LEN_W | Active instruction refill length in words |
| dlen_words | output | LEN_W | Active data refill length in words |
| halt_mode | output | 1 | Halt request to the power controller |
| snoop_inhibit | output | 1 | Data cache snooping unavailable |

## Verification
Some properties are checked by assertions on every cycle:
- The lock stays set once it is set.
- A locked write changes nothing and cannot start a halt.
- A pending interrupt always leaves halt cleared.
- The shadow outputs stay frozen while the bus is busy and copy the stored value when it is idle.
- The decoded lengths are always single powers of two, and the data length is 1 without burst-select.

Other behaviour can only be shown by the bench's scenarios:
- The exact size-code-to-word-count mapping.
- The reset value.
- Masking of the reserved bits.
- The fact that a lock-setting write still applies its other fields.
- The point in time at which a deferred change finally appears.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

   localparam int SIZE_W = 2;

   // Field order matches the bit positions 6..0 of the configuration word.
   typedef struct packed {
      logic              dcbr;
      logic              ice;
      logic              dce;
      logic [SIZE_W-1:0] isz;
      logic [SIZE_W-1:0] dsz;
   } cache_cfg_t;

   localparam cache_cfg_t CACHE_CFG_RST = '{dcbr: 1'b0, ice: 1'b1, dce: 1'b1,
                                            isz: '0, dsz: '0};

endpackage

// File: rtl/cfg_len_decode.sv
module cfg_len_decode
   import cfg_pkg::*;
#(
   parameter int LEN_W         = 6,
   parameter int BASE_WORDS    = 4,
   parameter bit HAS_BURST_SEL = 1'b0
) (
   input  logic [SIZE_W-1:0] size,
   input  logic              burst_sel,
   output logic [LEN_W-1:0]  words
);

   logic [LEN_W-1:0] burst_words;

   assign burst_words = LEN_W'(BASE_WORDS) << size;

   generate
      if (HAS_BURST_SEL) begin : g_sel
         assign words = burst_sel ? burst_words : LEN_W'(1);
      end else begin : g_fixed
         logic unused_sel;
         assign unused_sel = burst_sel;
         assign words = burst_words;
      end
   endgenerate

endmodule

// File: rtl/cfg_halt_ctl.sv
module cfg_halt_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ok,
   input  logic wr_halt,
   input  logic irq,
   input  logic nmi,
   output logic halt_q
);

   logic wake;

   assign wake = irq | nmi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
      end else if (wake) begin
         halt_q <= 1'b0;
      end else if (wr_ok) begin
         halt_q <= wr_halt;
      end
   end

   // R8
   wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq || nmi) |=> !halt_q);

   // R7
   halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && wr_halt && !irq && !nmi) |=> halt_q);

endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow
   import cfg_pkg::*;
#(
   parameter int LEN_W      = 6,
   parameter int BASE_WORDS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_busy,
   input  cache_cfg_t       soft_cfg,
   output cache_cfg_t       act_cfg,
   output logic [LEN_W-1:0] ilen_q,
   output logic [LEN_W-1:0] dlen_q
);

   localparam int NDEC = 2;

   logic [SIZE_W-1:0] dec_size [NDEC];
   logic              dec_sel  [NDEC];
   logic [LEN_W-1:0]  dec_len  [NDEC];

   assign dec_size[0] = soft_cfg.isz;
   assign dec_sel[0]  = 1'b1;
   assign dec_size[1] = soft_cfg.dsz;
   assign dec_sel[1]  = soft_cfg.dcbr;

   generate
      for (genvar gi = 0; gi < NDEC; gi++) begin : g_dec
         cfg_len_decode #(
            .LEN_W        (LEN_W),
            .BASE_WORDS   (BASE_WORDS),
            .HAS_BURST_SEL(gi == 1)
         ) i_dec (
            .size     (dec_size[gi]),
            .burst_sel(dec_sel[gi]),
            .words    (dec_len[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cfg <= CACHE_CFG_RST;
         ilen_q  <= LEN_W'(BASE_WORDS);
         dlen_q  <= LEN_W'(1);
      end else if (!bus_busy) begin
         act_cfg <= soft_cfg;
         ilen_q  <= dec_len[0];
         dlen_q  <= dec_len[1];
      end
   end

   // R6
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |=> ($stable(act_cfg) && $stable(ilen_q) && $stable(dlen_q)));

   // R6
   idle_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy |=> (act_cfg == $past(soft_cfg)));

   // R4
   len_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ilen_q) == 1) && ($countones(dlen_q) == 1));

   // R5
   dlen_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_cfg.dcbr |-> (dlen_q == LEN_W'(1)));

endmodule

// File: rtl/core_cfg_reg.sv
module core_cfg_reg
   import cfg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 6,
   parameter int BASE_WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              irq,
   input  logic              nmi,
   input  logic              bus_busy,
   output logic              icache_en,
   output logic              dcache_en,
   output logic [LEN_W-1:0]  ilen_words,
   output logic [LEN_W-1:0]  dlen_words,
   output logic              halt_mode,
   output logic              snoop_inhibit
);

   localparam int CFG_W    = $bits(cache_cfg_t);
   localparam int LOCK_BIT = CFG_W;
   localparam int HALT_BIT = CFG_W + 1;
   localparam int MAX_LEN  = BASE_WORDS << ((1 << SIZE_W) - 1);

   generate
      if (DATA_W < HALT_BIT + 1) begin : g_bad_data_w
         $error("DATA_W too small for configuration fields");
      end
      if (MAX_LEN >= (1 << LEN_W)) begin : g_bad_len_w
         $error("LEN_W cannot hold the largest refill length");
      end
      if (BASE_WORDS < 2) begin : g_bad_base
         $error("BASE_WORDS must be at least 2");
      end
   endgenerate

   logic       lock_q;
   logic       halt_q;
   logic       wr_ok;
   cache_cfg_t soft_q;
   cache_cfg_t act_cfg;

   assign wr_ok = wr_en & ~lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         soft_q <= CACHE_CFG_RST;
      end else if (wr_ok) begin
         lock_q <= wr_data[LOCK_BIT];
         soft_q <= wr_data[CFG_W-1:0];
      end
   end

   cfg_halt_ctl i_halt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ok  (wr_ok),
      .wr_halt(wr_data[HALT_BIT]),
      .irq    (irq),
      .nmi    (nmi),
      .halt_q (halt_q)
   );

   cfg_shadow #(
      .LEN_W     (LEN_W),
      .BASE_WORDS(BASE_WORDS)
   ) i_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_busy(bus_busy),
      .soft_cfg(soft_q),
      .act_cfg (act_cfg),
      .ilen_q  (ilen_words),
      .dlen_q  (dlen_words)
   );

   always_comb begin
      rd_data              = '0;
      rd_data[HALT_BIT]    = halt_q;
      rd_data[LOCK_BIT]    = lock_q;
      rd_data[CFG_W-1:0]   = soft_q;
   end

   assign icache_en     = act_cfg.ice;
   assign dcache_en     = act_cfg.dce;
   assign halt_mode     = halt_q;
   assign snoop_inhibit = halt_q;

   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R9
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_en) |=> $stable(soft_q));

   // R9
   locked_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !halt_q) |=> !halt_q);

   // R3
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:HALT_BIT+1] == '0);

endmodule

// File: tb/test_core_cfg_reg.sv
module test_core_cfg_reg;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq = 1'b0;
   logic        nmi = 1'b0;
   logic        bus_busy = 1'b0;
   logic        icache_en, dcache_en, halt_mode, snoop_inhibit;
   logic [5:0]  ilen_words, dlen_words;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   core_cfg_reg i_core_cfg_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_data      (rd_data),
      .irq          (irq),
      .nmi          (nmi),
      .bus_busy     (bus_busy),
      .icache_en    (icache_en),
      .dcache_en    (dcache_en),
      .ilen_words   (ilen_words),
      .dlen_words   (dlen_words),
      .halt_mode    (halt_mode),
      .snoop_inhibit(snoop_inhibit)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input logic ic, input logic dc,
                          input logic [5:0] il, input logic [5:0] dl);
      chk({req, " icache_en"}, 32'(icache_en), 32'(ic));
      chk({req, " dcache_en"}, 32'(dcache_en), 32'(dc));
      chk({req, " ilen_words"}, 32'(ilen_words), 32'(il));
      chk({req, " dlen_words"}, 32'(dlen_words), 32'(dl));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_wake(input bit use_nmi);
      @(negedge clk);
      if (use_nmi) nmi = 1'b1; else irq = 1'b1;
      @(negedge clk);
      nmi = 1'b0;
      irq = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 rd_data", rd_data, 32'h30);
      chk_out("R1", 1'b1, 1'b1, 6'd4, 6'd1);
      chk("R1 halt_mode", 32'(halt_mode), 0);
      chk("R1 snoop_inhibit", 32'(snoop_inhibit), 0);
   endtask

   task automatic t_fields();
      wr(32'h4F);
      chk("R2 rd_data", rd_data, 32'h4F);
      @(negedge clk);
      chk_out("R4 R5 burst 11/11", 1'b0, 1'b0, 6'd32, 6'd32);
      wr(32'h36);
      @(negedge clk);
      chk_out("R4 R5 single", 1'b1, 1'b1, 6'd8, 6'd1);
      wr(32'h68);
      @(negedge clk);
      chk_out("R4 R5 16/4", 1'b1, 1'b0, 6'd16, 6'd4);
   endtask

   task automatic t_reserved();
      wr(32'hFFFF_FE30);
      chk("R3 rd_data", rd_data, 32'h30);
      chk("R3 halt_mode", 32'(halt_mode), 0);
   endtask

   task automatic t_defer();
      @(negedge clk);
      bus_busy = 1'b1;
      wr(32'h45);
      chk("R2 rd while busy", rd_data, 32'h45);
      repeat (3) @(negedge clk);
      chk_out("R6 held", 1'b1, 1'b1, 6'd4, 6'd1);
      bus_busy = 1'b0;
      @(negedge clk);
      chk_out("R6 applied", 1'b0, 1'b0, 6'd8, 6'd8);
   endtask

   task automatic t_halt(input bit use_nmi);
      wr(32'h130);
      chk("R7 halt_mode set", 32'(halt_mode), 1);
      chk("R7 snoop_inhibit set", 32'(snoop_inhibit), 1);
      chk("R7 rd_data", rd_data, 32'h130);
      pulse_wake(use_nmi);
      chk("R8 halt_mode cleared", 32'(halt_mode), 0);
      chk("R8 rd_data", rd_data, 32'h30);
   endtask

   task automatic t_halt_clear_by_write();
      wr(32'h130);
      wr(32'h30);
      chk("R7 halt cleared by write", 32'(halt_mode), 0);
   endtask

   task automatic t_halt_vs_irq();
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 32'h130;
      irq = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      irq = 1'b0;
      chk("R8 wake beats write", 32'(halt_mode), 0);
   endtask

   task automatic t_lock();
      wr(32'hB5);
      chk("R10 rd_data", rd_data, 32'hB5);
      @(negedge clk);
      chk_out("R10 outputs", 1'b1, 1'b1, 6'd8, 6'd1);
      wr(32'h00);
      chk("R9 ignored write", rd_data, 32'hB5);
      wr(32'h1CF);
      chk("R9 halt blocked", 32'(halt_mode), 0);
      chk("R9 still locked", rd_data, 32'hB5);
      @(negedge clk);
      chk_out("R9 outputs kept", 1'b1, 1'b1, 6'd8, 6'd1);
      do_reset();
      chk("R9 reset unlocks", rd_data, 32'h30);
      wr(32'h0C);
      chk("R9 writable after reset", rd_data, 32'h0C);
   endtask

   initial begin
      t_reset();
      t_fields();
      t_reserved();
      t_defer();
      t_halt(1'b0);
      t_halt(1'b1);
      t_halt_clear_by_write();
      t_halt_vs_irq();
      t_lock();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule